// File: doc/BRIEF.md
# Four-Bank Pin Controller with Edge Interrupts

This block is a register-mapped controller for 128 general-purpose pins. The pins are grouped into four banks of 32. Each pin has a direction bit and an output latch. Software changes the latch only through two write-only ports: one sets bits and one clears them. A pad output carries the latch value only while its pin is an output. A pin-level view returns the latch for output pins and the sampled pad for input pins.

Input pins can be armed for rising or falling edges. A detected edge sets a sticky status bit, which software clears by writing ones. Status drives three level interrupts: one each for pins 0 and 1, and one shared line for every other pin. While the system sleeps, a fixed set of wake-capable input pins raises a wake request whenever one of them changes level. Every read of a pin-level register pulses a read strobe in the cycle of the read.

The register bus is a plain single-cycle port. A write takes effect at the clock edge on which the write enable is sampled high. Read data is combinational from the address. Pin bank b holds pins 32*b to 32*b+31, with pin n at bit n mod 32.

Top module: `pin_bank_gpio`

## Requirements
- R1: After reset, every direction, latch, edge-enable, status and alternate-function register is 0, every pad output is 0, and all three interrupts and the wake request are low.
- R2: Reading a bank's pin-level register returns `(latch & dir) | (sampledIn & ~dir)`, where a direction bit of 1 means output. The sampled input is the pad value registered once.
- R3: `readNotify` is high in exactly those cycles in which `busRe` is high and the address selects the pin-level register of any bank.
- R4: Writing the set register ORs the write data into the bank's latch. Writing the clear register clears the latch bits written as 1. Both registers read as 0.
- R5: A status bit is set one clock after the sampled level of an input pin rises (with its rising enable at 1) or falls (with its falling enable at 1). Output pins never set status. Status bits stay set until cleared.
- R6: Writing the status register clears the bits written as 1 and leaves the other bits unchanged. If an edge lands on the same clock as the clear of that bit, the bit stays set.
- R7: `irqPin0` equals status bit 0 of bank 0, and `irqPin1` equals status bit 1 of bank 0. `irqOther` is high while any other status bit of any bank is set.
- R8: The byte offsets for banks 0, 1, 2 and 3 are as follows. The last bank of each register is relocated by 0x100.
  - pin level: 0x000, 0x004, 0x008, 0x100
  - direction: 0x00C, 0x010, 0x014, 0x10C
  - set: 0x018, 0x01C, 0x020, 0x118
  - clear: 0x024, 0x028, 0x02C, 0x124
  - rising enable: 0x030, 0x034, 0x038, 0x130
  - falling enable: 0x03C, 0x040, 0x044, 0x13C
  - status: 0x048, 0x04C, 0x050, 0x148
- R9: The alternate-function words are plain read/write storage, with no effect on the pins. The low word of bank b is at 0x054+8*b and the high word is at 0x058+8*b.
- R10: Accesses at offset 0x200 or above, and unmapped or unaligned offsets below it, change no state and read as 0.
- R11: Each pad output equals its latch bit ANDed with its direction bit.
- R12: While `sleepIn` is high, `wakeReq` is high in the cycle after an input pin changes sampled level, if that pin is in the fixed wake mask. The masks for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (12) | Byte offset of the access |
| busWe | input | 1 | Write enable |
| busRe | input | 1 | Read enable (drives the read strobe) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| padIn | input | 128 | Pad input levels |
| padOut | output | 128 | Pad output levels |
| sleepIn | input | 1 | System is sleeping; arms wake detection |
| irqPin0 | output | 1 | Level interrupt for pin 0 |
| irqPin1 | output | 1 | Level interrupt for pin 1 |
| irqOther | output | 1 | Shared level interrupt for pins 2 to 127 |
| wakeReq | output | 1 | Wake request |
| readNotify | output | 1 | Pulse on each pin-level register read |

## Verification
The assertions take the bus inputs to be known values whenever the block is out of reset. They also assume that a clear of status bit 0 is only meaningful when no edge on pin 0 falls on the same clock, which is the case the sticky and clear properties separate through the internal edge vector. The stimulus issues at most one access per cycle, with an idle cycle between accesses. It moves the pads only at the falling clock edge and one pin at a time, so each expected wake pulse and status bit traces back to a single edge. The one deliberate collision between an edge and a clear is scheduled so that both land on the same rising edge.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  localparam int BANKS  = 4;
  localparam int BANK_W = 32;
  localparam int PINS   = BANKS * BANK_W;
  localparam int BANK_IDX_W = $clog2(BANKS);
  localparam int WIN_END = 32'h200;   // accesses at or above this are ignored
  localparam int RELOC   = 32'h100;   // window of the last bank
  localparam int STRIDE  = 12;        // distance between register groups

  // order matters: kinds 1..7 sit at STRIDE*(kind-1) inside a bank window
  typedef enum logic [3:0] {
    RK_NONE, RK_LEVEL, RK_DIR, RK_SET, RK_CLR, RK_RISE, RK_FALL, RK_STAT,
    RK_ALTLO, RK_ALTHI
  } regKind_e;

  typedef struct packed {
    regKind_e                rdKind;
    logic [BANK_IDX_W-1:0]   bank;
    logic                    wrDir;
    logic                    wrSet;
    logic                    wrClr;
    logic                    wrRise;
    logic                    wrFall;
    logic                    wrStat;
    logic                    wrAltLo;
    logic                    wrAltHi;
  } pbStrobe_t;

  function automatic logic [BANK_W-1:0] wakeMask(input int b);
    case (b)
      0:       wakeMask = 32'h8003FE1B;
      1:       wakeMask = 32'h002001FC;
      2:       wakeMask = 32'hEC080000;
      default: wakeMask = 32'h0012007F;
    endcase
  endfunction
endpackage

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output pbStrobe_t         strobe,
  output logic              readNotify
);
  logic [31:0] addr32;
  logic [31:0] bankBase;
  regKind_e    kind;
  logic [BANK_IDX_W-1:0] bankSel;

  always_comb begin
    addr32   = 32'(busAddr);
    kind     = RK_NONE;
    bankSel  = '0;
    bankBase = '0;
    if (addr32 < 32'(WIN_END) && addr32[1:0] == 2'b00) begin
      for (int b = 0; b < BANKS; b++) begin
        bankBase = (b == BANKS - 1) ? 32'(RELOC) : 32'(4 * b);
        for (int k = 0; k < 7; k++) begin
          if (addr32 == bankBase + 32'(STRIDE * k)) begin
            kind    = regKind_e'(k + 1);
            bankSel = BANK_IDX_W'(b);
          end
        end
        if (addr32 == 32'h054 + 32'(8 * b)) begin
          kind    = RK_ALTLO;
          bankSel = BANK_IDX_W'(b);
        end
        if (addr32 == 32'h058 + 32'(8 * b)) begin
          kind    = RK_ALTHI;
          bankSel = BANK_IDX_W'(b);
        end
      end
    end
  end

  always_comb begin
    strobe.rdKind  = kind;
    strobe.bank    = bankSel;
    strobe.wrDir   = busWe && kind == RK_DIR;
    strobe.wrSet   = busWe && kind == RK_SET;
    strobe.wrClr   = busWe && kind == RK_CLR;
    strobe.wrRise  = busWe && kind == RK_RISE;
    strobe.wrFall  = busWe && kind == RK_FALL;
    strobe.wrStat  = busWe && kind == RK_STAT;
    strobe.wrAltLo = busWe && kind == RK_ALTLO;
    strobe.wrAltHi = busWe && kind == RK_ALTHI;
    readNotify     = busRe && kind == RK_LEVEL;
  end
endmodule

// File: rtl/pin_bank_datapath.sv
module pin_bank_datapath
  import pin_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pbStrobe_t         strobe,
  input  logic [BANK_W-1:0] busWdata,
  output logic [BANK_W-1:0] busRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  input  logic              sleepIn,
  output logic              irqPin0,
  output logic              irqPin1,
  output logic              irqOther,
  output logic              wakeReq,
  output logic [PINS-1:0]   edgeHit
);
  logic [BANKS-1:0][BANK_W-1:0] dirR, latchR, riseR, fallR, statR, altLoR, altHiR;
  logic [BANKS-1:0][BANK_W-1:0] inLvl, prevLvl, edgeB, wakeB;
  logic [BANKS-1:0]             bankHit;

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic [BANK_W-1:0] clrMask;
    assign bankHit[g] = strobe.bank == BANK_IDX_W'(g);
    assign edgeB[g] = ~dirR[g] & ((riseR[g] & inLvl[g] & ~prevLvl[g]) |
                                  (fallR[g] & ~inLvl[g] & prevLvl[g]));
    assign wakeB[g] = (inLvl[g] ^ prevLvl[g]) & ~dirR[g] & wakeMask(g);
    assign clrMask  = (strobe.wrStat && bankHit[g]) ? busWdata : '0;
    assign padOut[g*BANK_W +: BANK_W]  = latchR[g] & dirR[g];
    assign edgeHit[g*BANK_W +: BANK_W] = edgeB[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dirR[g] <= '0; latchR[g] <= '0; riseR[g] <= '0; fallR[g] <= '0;
        statR[g] <= '0; altLoR[g] <= '0; altHiR[g] <= '0;
        inLvl[g] <= '0; prevLvl[g] <= '0;
      end else begin
        inLvl[g]   <= padIn[g*BANK_W +: BANK_W];
        prevLvl[g] <= inLvl[g];
        // a fresh edge overrides a same-cycle clear
        statR[g]   <= (statR[g] & ~clrMask) | edgeB[g];
        if (bankHit[g]) begin
          if (strobe.wrDir)   dirR[g]   <= busWdata;
          if (strobe.wrSet)   latchR[g] <= latchR[g] | busWdata;
          if (strobe.wrClr)   latchR[g] <= latchR[g] & ~busWdata;
          if (strobe.wrRise)  riseR[g]  <= busWdata;
          if (strobe.wrFall)  fallR[g]  <= busWdata;
          if (strobe.wrAltLo) altLoR[g] <= busWdata;
          if (strobe.wrAltHi) altHiR[g] <= busWdata;
        end
      end
    end
  end

  always_comb begin
    logic otherAny;
    irqPin0  = statR[0][0];
    irqPin1  = statR[0][1];
    otherAny = |statR[0][BANK_W-1:2];
    for (int b = 1; b < BANKS; b++) otherAny = otherAny | (|statR[b]);
    irqOther = otherAny;
  end

  always_comb begin
    logic anyWake;
    anyWake = 1'b0;
    for (int b = 0; b < BANKS; b++) anyWake = anyWake | (|wakeB[b]);
    wakeReq = sleepIn && anyWake;
  end

  always_comb begin
    case (strobe.rdKind)
      RK_LEVEL: busRdata = (latchR[strobe.bank] & dirR[strobe.bank]) |
                           (inLvl[strobe.bank] & ~dirR[strobe.bank]);
      RK_DIR:   busRdata = dirR[strobe.bank];
      RK_RISE:  busRdata = riseR[strobe.bank];
      RK_FALL:  busRdata = fallR[strobe.bank];
      RK_STAT:  busRdata = statR[strobe.bank];
      RK_ALTLO: busRdata = altLoR[strobe.bank];
      RK_ALTHI: busRdata = altHiR[strobe.bank];
      default:  busRdata = '0;   // set, clear, unmapped
    endcase
  end
endmodule

// File: rtl/pin_bank_gpio.sv
module pin_bank_gpio
  import pin_bank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [127:0]      padIn,
  output logic [127:0]      padOut,
  input  logic              sleepIn,
  output logic              irqPin0,
  output logic              irqPin1,
  output logic              irqOther,
  output logic              wakeReq,
  output logic              readNotify
);
  pbStrobe_t         strobe;
  logic [PINS-1:0]   edgeHit;

  pin_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .strobe(strobe), .readNotify(readNotify)
  );

  pin_bank_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .padIn(padIn), .padOut(padOut), .sleepIn(sleepIn),
    .irqPin0(irqPin0), .irqPin1(irqPin1), .irqOther(irqOther),
    .wakeReq(wakeReq), .edgeHit(edgeHit)
  );
endmodule

// File: rtl/pin_bank_gpio_chk.sv
module pin_bank_gpio_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              busRe,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [127:0]      padOut,
  input logic              sleepIn,
  input logic              irqPin0,
  input logic              wakeReq,
  input logic              readNotify,
  input logic [127:0]      edgeHit
);
  logic clrBit0;
  assign clrBit0 = busWe && 32'(busAddr) == 32'h048 && busWdata[0];

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqPin0 && !clrBit0) |=> irqPin0);                          // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (clrBit0 && !edgeHit[0]) |=> !irqPin0);                       // R6
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (clrBit0 && edgeHit[0]) |=> irqPin0);                         // R6
  AST_NOTIFY_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    readNotify |-> busRe);                                        // R3
  AST_HIGH_WINDOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (32'(busAddr) >= 32'h200) |-> busRdata == 32'h0);            // R10
  AST_PADS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> $stable(padOut));                                  // R11
  AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> sleepIn);                                         // R12
endmodule

bind pin_bank_gpio pin_bank_gpio_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
  .busWdata(busWdata), .busRdata(busRdata), .padOut(padOut), .sleepIn(sleepIn),
  .irqPin0(irqPin0), .wakeReq(wakeReq), .readNotify(readNotify), .edgeHit(edgeHit)
);

// File: tb/pin_bank_gpio_tb.sv
module pin_bank_gpio_tb;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [11:0]  busAddr = '0;
  logic         busWe = 1'b0, busRe = 1'b0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic [127:0] padIn = '0;
  logic [127:0] padOut;
  logic         sleepIn = 1'b0;
  logic         irqPin0, irqPin1, irqOther, wakeReq, readNotify;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] data;
    logic        notify;
    string       tag;
  } rdExp_t;
  rdExp_t q[$];

  always #(CLK_P/2) clk = ~clk;

  pin_bank_gpio u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .padOut(padOut),
    .sleepIn(sleepIn), .irqPin0(irqPin0), .irqPin1(irqPin1),
    .irqOther(irqOther), .wakeReq(wakeReq), .readNotify(readNotify)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results as the design presents them
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (busRe) begin
      if (q.size() == 0) begin
        vecs++; errs++;
        $display("FAIL R3 unexpected read actual=%h expected=none", busRdata);
      end else begin
        rdExp_t e;
        e = q.pop_front();
        chk({e.tag, " data"}, 128'(busRdata), 128'(e.data));
        chk({e.tag, " notify"}, 128'(readNotify), 128'(e.notify));
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, logic notify, string tag);
    rdExp_t e;
    @(negedge clk);
    e.data = exp; e.notify = notify; e.tag = tag;
    q.push_back(e);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  // move one pad, check the wake pulse after it is sampled, then let status settle
  task automatic setPad(int idx, logic v, logic expWake);
    @(negedge clk);
    padIn[idx] = v;
    @(negedge clk);
    #1 chk("R12 wake", 128'(wakeReq), 128'(expWake));
    @(negedge clk);
  endtask

  task automatic peekIrq(string tag, logic [2:0] exp);
    #1 chk(tag, 128'({irqPin0, irqPin1, irqOther}), 128'(exp));
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    #1 chk("R1 padOut", padOut, '0);
    peekIrq("R1 irqs", 3'b000);
    chk("R1 wake", 128'(wakeReq), 128'h0);
    rd(12'h000, 32'h0, 1'b1, "R1 level0");
    rd(12'h00C, 32'h0, 1'b0, "R1 dir0");

    // R2, R4, R11 on bank 0
    padIn[31:0] = 32'h0000AA00;
    repeat (2) @(negedge clk);
    wr(12'h00C, 32'h000000FF);
    wr(12'h018, 32'hF0F0F0F5);
    #1 chk("R11 padOut bank0", 128'(padOut[31:0]), 128'h000000F5);
    rd(12'h000, 32'h0000AAF5, 1'b1, "R2 level mix");
    rd(12'h018, 32'h0, 1'b0, "R4 set reads zero");
    wr(12'h024, 32'h00000005);
    #1 chk("R4 clear", 128'(padOut[31:0]), 128'h000000F0);
    rd(12'h024, 32'h0, 1'b0, "R4 clear reads zero");
    rd(12'h000, 32'h0000AAF0, 1'b1, "R2 level after clear");

    // R8 relocated bank 3, bank 2 direction
    wr(12'h10C, 32'hFFFF0000);
    wr(12'h118, 32'h12345678);
    #1 chk("R8 bank3 pads", 128'(padOut[127:96]), 128'h12340000);
    rd(12'h10C, 32'hFFFF0000, 1'b0, "R8 bank3 dir");
    rd(12'h100, 32'h12340000, 1'b1, "R8 bank3 level");
    wr(12'h014, 32'h0000000F);
    #1 chk("R11 dir alone", 128'(padOut[95:64]), 128'h0);
    rd(12'h014, 32'h0000000F, 1'b0, "R8 bank2 dir");

    // R9 alternate-function words
    wr(12'h054, 32'hDEADBEEF);
    wr(12'h070, 32'hCAFEF00D);
    wr(12'h060, 32'h11112222);
    rd(12'h054, 32'hDEADBEEF, 1'b0, "R9 bank0 low");
    rd(12'h070, 32'hCAFEF00D, 1'b0, "R9 bank3 high");
    rd(12'h060, 32'h11112222, 1'b0, "R9 bank1 high");
    rd(12'h058, 32'h0, 1'b0, "R9 bank0 high untouched");

    // R5, R7 edges on bank 0
    wr(12'h00C, 32'h0);
    wr(12'h030, 32'h00000001);
    wr(12'h03C, 32'h00000002);
    setPad(0, 1'b1, 1'b0);
    peekIrq("R5 R7 rise pin0", 3'b100);
    setPad(1, 1'b1, 1'b0);
    peekIrq("R5 rise not armed pin1", 3'b100);
    setPad(1, 1'b0, 1'b0);
    peekIrq("R5 R7 fall pin1", 3'b110);
    rd(12'h048, 32'h00000003, 1'b0, "R5 status bank0");

    // R6 write-one-to-clear
    wr(12'h048, 32'h00000001);
    peekIrq("R6 clear bit0 only", 3'b010);
    rd(12'h048, 32'h00000002, 1'b0, "R6 status after clear");

    // R5 output pin ignored, then R7 shared line from bank 1
    wr(12'h010, 32'h00000010);
    wr(12'h034, 32'h00000010);
    setPad(36, 1'b1, 1'b0);
    peekIrq("R5 output pin no edge", 3'b010);
    wr(12'h010, 32'h0);
    setPad(36, 1'b0, 1'b0);
    setPad(36, 1'b1, 1'b0);
    peekIrq("R7 shared line", 3'b011);
    rd(12'h04C, 32'h00000010, 1'b0, "R7 status bank1");
    wr(12'h04C, 32'h00000010);
    peekIrq("R6 clear bank1", 3'b010);

    // R6 edge and clear on the same clock
    setPad(36, 1'b0, 1'b0);
    @(negedge clk);
    padIn[36] = 1'b1;
    @(negedge clk);
    busAddr = 12'h04C; busWdata = 32'h00000010; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    peekIrq("R6 edge wins", 3'b011);
    wr(12'h04C, 32'h00000010);
    peekIrq("R6 cleared after", 3'b010);

    // R12 wake
    sleepIn = 1'b1;
    setPad(3, 1'b1, 1'b1);
    setPad(2, 1'b1, 1'b0);
    sleepIn = 1'b0;
    setPad(3, 1'b0, 1'b0);
    wr(12'h00C, 32'h00000010);
    sleepIn = 1'b1;
    setPad(4, 1'b1, 1'b0);
    sleepIn = 1'b0;

    // R10 ignored windows
    wr(12'h248, 32'hFFFFFFFF);
    peekIrq("R10 high window write", 3'b010);
    rd(12'h200, 32'h0, 1'b0, "R10 read 0x200");
    rd(12'h248, 32'h0, 1'b0, "R10 read 0x248");
    wr(12'h074, 32'h55555555);
    rd(12'h074, 32'h0, 1'b0, "R10 unmapped");
    wr(12'h04A, 32'hFFFFFFFF);
    peekIrq("R10 unaligned write", 3'b010);

    repeat (2) @(negedge clk);
    chk("R3 all reads seen", 128'(q.size()), 128'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule